// File: doc/BRIEF.md
# Converter Startup and Fault Sequencer

This block decides when the two pulse-width modulators of an isolated converter may switch. It takes digital comparator flags from the analog front end and produces two run enables. `run1` releases the auxiliary modulator, which builds the bootstrap supply. `run2` releases the main modulator once the bootstrap supply has risen above the main supply. Every flag arrives asynchronously and is resynchronised before use.

Two fault classes are handled.

- An input fault is a bad reference, a low input line, a high input line, or a disabled state. It stops both modulators. The sequence restarts by itself once the fault is gone and the bootstrap supply has collapsed.
- An output-undervoltage timeout is measured by a digital counter in place of a charging capacitor. It counts while either output feedback flag sits high. The timeout latches, and it is released only by a specific recovery sequence: both feedbacks must read low, and the enable input or the line-undervoltage flag must be toggled while the bootstrap supply is collapsed.

The terminal count is a parameter-width input, normally driven from a configuration register.

Top module: `supply_seq`

## Requirements
- R1: The polarity of `enableIn` is chosen by `programIn`. With `programIn`=1, `enableIn`=0 enables the block. With `programIn`=0, `enableIn`=1 enables it. The opposite level is a disable condition.
- R2: Each of these is an input fault: `vrefOk`=0, `uvOk`=0, `ovFault`=1, or disabled. While running, an input fault drives `run1` and `run2` low at the third rising clock edge after the pin change.
- R3: From the waiting state, `run1` rises at the third rising edge after the last input fault clears. `run2` is never high without `run1`. `run2` rises at the third edge after `vssAboveMain` goes high while `run1` is high.
- R4: After an input fault, `run1` stays low until both of these hold: the fault is gone and `vssCollapsed`=1. `run1` then rises at the fourth edge after `vssCollapsed` is seen high.
- R5: While running, if `fb1High` or `fb2High` stays high, `ouvFault` rises, and `run1` and `run2` fall, at the (L+3)-th edge after the flag rises, where L is `timerLimit`.
- R6: The timer restarts from zero whenever both feedback flags are low. High pulses shorter than L cycles, separated by low cycles, never raise `ouvFault`.
- R7: `ouvFault` holds through all input changes. It clears, and the sequence restarts through the waiting state, only when `fb1High`=`fb2High`=0, `vssCollapsed`=1, and a change of the decoded enable or of `uvOk` has been seen while `vssCollapsed`=1. Toggles made while `vssCollapsed`=0 do not count.
- R8: During and right after reset, `run1`, `run2` and `ouvFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vrefOk | input | 1 | Internal reference within range |
| uvOk | input | 1 | Input line above undervoltage threshold |
| ovFault | input | 1 | Input line above overvoltage threshold |
| enableIn | input | 1 | Enable pin, polarity set by programIn |
| programIn | input | 1 | Enable polarity select |
| vssAboveMain | input | 1 | Bootstrap supply exceeds main supply |
| vssCollapsed | input | 1 | Bootstrap supply below restart level |
| fb1High | input | 1 | Auxiliary feedback above output-undervoltage threshold |
| fb2High | input | 1 | Main feedback above output-undervoltage threshold |
| timerLimit | input | CNT_W | Terminal count of the output-undervoltage timer |
| run1 | output | 1 | Auxiliary modulator release |
| run2 | output | 1 | Main modulator release |
| ouvFault | output | 1 | Latched output-undervoltage fault |

## Verification
Several rules are checked by the assertions on every cycle:
- `run2` never appears without `run1`;
- a synchronised input fault removes both enables one cycle later;
- a timer expiry latches the fault;
- the latched fault never falls unless the recovery conditions held the cycle before;
- the waiting-for-restart state never leaves while the bootstrap supply is high.

Other behaviour can only be shown by bench scenarios. These are the exact latencies through the synchronisers, the enable polarity across random flag combinations, the restarting of the timer on short feedback pulses, and the refusal to clear the latch on toggles made while the bootstrap supply is still up.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

  localparam int NUM_FLAGS = 9;

  localparam int FLAG_VREF   = 0;
  localparam int FLAG_UV     = 1;
  localparam int FLAG_OV     = 2;
  localparam int FLAG_EN     = 3;
  localparam int FLAG_PROG   = 4;
  localparam int FLAG_VSSGT  = 5;
  localparam int FLAG_VSSLOW = 6;
  localparam int FLAG_FB1    = 7;
  localparam int FLAG_FB2    = 8;

  typedef enum logic [2:0] {
    ST_WAIT_REF     = 3'd0,
    ST_RUN_AUX      = 3'd1,
    ST_RUN_BOTH     = 3'd2,
    ST_WAIT_RESTART = 3'd3,
    ST_LATCHED      = 3'd4
  } seqState_t;

  typedef struct packed {
    logic timerRun;
    logic toggleArm;
  } ctrlStrobe_t;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import supply_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] flagSync,
  input  logic [CNT_W-1:0]     timerLimit,
  input  ctrlStrobe_t          strobe,
  output logic                 inputFault,
  output logic                 fb1S,
  output logic                 fb2S,
  output logic                 vssGtS,
  output logic                 vssLowS,
  output logic                 timerExpired,
  output logic                 toggleSeen
);

  logic             enabledS;
  logic             uvS;
  logic             fbAny;
  logic [CNT_W-1:0] ouvCnt;
  logic             prevEnabled;
  logic             prevUv;
  logic             edgeSeen;

  // Enable polarity and the input fault decode.
  assign enabledS   = flagSync[FLAG_PROG] ? ~flagSync[FLAG_EN] : flagSync[FLAG_EN];
  assign uvS        = flagSync[FLAG_UV];
  assign inputFault = ~flagSync[FLAG_VREF] | ~uvS | flagSync[FLAG_OV] | ~enabledS;
  assign fb1S       = flagSync[FLAG_FB1];
  assign fb2S       = flagSync[FLAG_FB2];
  assign vssGtS     = flagSync[FLAG_VSSGT];
  assign vssLowS    = flagSync[FLAG_VSSLOW];
  assign fbAny      = fb1S | fb2S;

  // Output-undervoltage timer: restarts from zero whenever idle or both feedbacks low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               ouvCnt <= '0;
    else if (!strobe.timerRun || !fbAny)     ouvCnt <= '0;
    else if (ouvCnt < timerLimit)            ouvCnt <= ouvCnt + 1'b1;
  end

  assign timerExpired = strobe.timerRun && fbAny && (ouvCnt >= timerLimit);

  assert_timer_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.timerRun || !fbAny) |=> (ouvCnt == '0));

  // Toggle detector used for releasing the latched timer fault.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEnabled <= 1'b0;
      prevUv      <= 1'b0;
    end else begin
      prevEnabled <= enabledS;
      prevUv      <= uvS;
    end
  end

  assign edgeSeen = (enabledS != prevEnabled) || (uvS != prevUv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     toggleSeen <= 1'b0;
    else if (!strobe.toggleArm)    toggleSeen <= 1'b0;
    else if (edgeSeen && vssLowS)  toggleSeen <= 1'b1;
  end

  assert_toggle_needs_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.toggleArm && !vssLowS && !toggleSeen) |=> !toggleSeen);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import supply_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inputFault,
  input  logic        fb1S,
  input  logic        fb2S,
  input  logic        vssGtS,
  input  logic        vssLowS,
  input  logic        timerExpired,
  input  logic        toggleSeen,
  output ctrlStrobe_t strobe,
  output logic        run1,
  output logic        run2,
  output logic        ouvFault
);

  seqState_t stQ;
  seqState_t stD;

  always_comb begin
    stD = stQ;
    unique case (stQ)
      ST_WAIT_REF: begin
        if (!inputFault) stD = ST_RUN_AUX;
      end
      ST_RUN_AUX: begin
        if (inputFault)        stD = ST_WAIT_RESTART;
        else if (timerExpired) stD = ST_LATCHED;
        else if (vssGtS)       stD = ST_RUN_BOTH;
      end
      ST_RUN_BOTH: begin
        if (inputFault)        stD = ST_WAIT_RESTART;
        else if (timerExpired) stD = ST_LATCHED;
      end
      ST_WAIT_RESTART: begin
        if (!inputFault && vssLowS) stD = ST_WAIT_REF;
      end
      ST_LATCHED: begin
        if (toggleSeen && vssLowS && !fb1S && !fb2S) stD = ST_WAIT_REF;
      end
      default: stD = ST_WAIT_REF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_WAIT_REF;
    else       stQ <= stD;
  end

  assign run1     = (stQ == ST_RUN_AUX) || (stQ == ST_RUN_BOTH);
  assign run2     = (stQ == ST_RUN_BOTH);
  assign ouvFault = (stQ == ST_LATCHED);

  assign strobe.timerRun  = run1;
  assign strobe.toggleArm = ouvFault;

  assert_run2_needs_run1_R3: assert property (@(posedge clk) disable iff (!rstN)
    run2 |-> run1);

  assert_fault_drops_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inputFault && run1) |=> (!run1 && !run2));

  assert_expiry_latches_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timerExpired && run1 && !inputFault) |=> ouvFault);

  assert_latch_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ouvFault) |-> ($past(vssLowS) && !$past(fb1S) && !$past(fb2S) && $past(toggleSeen)));

  assert_restart_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((stQ == ST_WAIT_RESTART) && !vssLowS) |=> (stQ == ST_WAIT_RESTART));

endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import supply_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vrefOk,
  input  logic             uvOk,
  input  logic             ovFault,
  input  logic             enableIn,
  input  logic             programIn,
  input  logic             vssAboveMain,
  input  logic             vssCollapsed,
  input  logic             fb1High,
  input  logic             fb2High,
  input  logic [CNT_W-1:0] timerLimit,
  output logic             run1,
  output logic             run2,
  output logic             ouvFault
);

  logic [NUM_FLAGS-1:0] flagRaw;
  logic [NUM_FLAGS-1:0] flagSync;
  ctrlStrobe_t          strobe;
  logic                 inputFault;
  logic                 fb1S;
  logic                 fb2S;
  logic                 vssGtS;
  logic                 vssLowS;
  logic                 timerExpired;
  logic                 toggleSeen;

  always_comb begin
    flagRaw              = '0;
    flagRaw[FLAG_VREF]   = vrefOk;
    flagRaw[FLAG_UV]     = uvOk;
    flagRaw[FLAG_OV]     = ovFault;
    flagRaw[FLAG_EN]     = enableIn;
    flagRaw[FLAG_PROG]   = programIn;
    flagRaw[FLAG_VSSGT]  = vssAboveMain;
    flagRaw[FLAG_VSSLOW] = vssCollapsed;
    flagRaw[FLAG_FB1]    = fb1High;
    flagRaw[FLAG_FB2]    = fb2High;
  end

  seq_sync #(.WIDTH(NUM_FLAGS), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (flagRaw),
    .syncOut (flagSync)
  );

  seq_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .flagSync     (flagSync),
    .timerLimit   (timerLimit),
    .strobe       (strobe),
    .inputFault   (inputFault),
    .fb1S         (fb1S),
    .fb2S         (fb2S),
    .vssGtS       (vssGtS),
    .vssLowS      (vssLowS),
    .timerExpired (timerExpired),
    .toggleSeen   (toggleSeen)
  );

  seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inputFault   (inputFault),
    .fb1S         (fb1S),
    .fb2S         (fb2S),
    .vssGtS       (vssGtS),
    .vssLowS      (vssLowS),
    .timerExpired (timerExpired),
    .toggleSeen   (toggleSeen),
    .strobe       (strobe),
    .run1         (run1),
    .run2         (run2),
    .ouvFault     (ouvFault)
  );

endmodule

// File: tb/supply_seq_tb.sv
`timescale 1ns/1ps
module supply_seq_tb;

  localparam int CNT_W = 16;
  localparam int LIM   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vrefOk = 0, uvOk = 0, ovFault = 0, enableIn = 0, programIn = 0;
  logic vssAboveMain = 0, vssCollapsed = 1, fb1High = 0, fb2High = 0;
  logic [CNT_W-1:0] timerLimit = CNT_W'(LIM);
  logic run1, run2, ouvFault;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supply_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .vrefOk(vrefOk), .uvOk(uvOk), .ovFault(ovFault),
    .enableIn(enableIn), .programIn(programIn), .vssAboveMain(vssAboveMain),
    .vssCollapsed(vssCollapsed), .fb1High(fb1High), .fb2High(fb2High),
    .timerLimit(timerLimit), .run1(run1), .run2(run2), .ouvFault(ouvFault)
  );

  function automatic logic expRun1(logic vr, logic uv, logic ov, logic en, logic pr);
    logic enabled;
    enabled = pr ? ~en : en;
    return vr & uv & ~ov & enabled;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic actual, input logic expected);
    testCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, actual, expected, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    check("R8 run1", run1, 1'b0);
    check("R8 run2", run2, 1'b0);
    check("R8 ouvFault", ouvFault, 1'b0);
    rstN = 1'b1;
    step(3);
    check("R8 run1 after release", run1, 1'b0);

    // R3 startup latency
    vrefOk = 1; uvOk = 1; enableIn = 1;
    step(2); check("R3 run1 early", run1, 1'b0);
    step(1); check("R3 run1 rise", run1, 1'b1);
    check("R3 run2 waits", run2, 1'b0);
    vssAboveMain = 1;
    step(2); check("R3 run2 early", run2, 1'b0);
    step(1); check("R3 run2 rise", run2, 1'b1);

    // R2 input fault, R4 restart gating
    ovFault = 1; vssAboveMain = 0; vssCollapsed = 0;
    step(2); check("R2 run1 early", run1, 1'b1);
    step(1); check("R2 run1 drop", run1, 1'b0);
    check("R2 run2 drop", run2, 1'b0);
    ovFault = 0;
    step(6); check("R4 no restart while supply up", run1, 1'b0);
    vssCollapsed = 1;
    step(3); check("R4 run1 not yet", run1, 1'b0);
    step(1); check("R4 run1 restart", run1, 1'b1);

    // R1 polarity
    programIn = 1;
    step(3); check("R1 high enable disables when program high", run1, 1'b0);
    enableIn = 0;
    step(6); check("R1 low enable enables when program high", run1, 1'b1);

    // R6 short pulses never accumulate
    for (int k = 0; k < 3; k++) begin
      fb1High = 1; step(LIM - 2);
      fb1High = 0; step(1);
      fb2High = 1; step(LIM - 2);
      fb2High = 0; step(1);
    end
    step(4);
    check("R6 no latch on short pulses", ouvFault, 1'b0);
    check("R6 still running", run1, 1'b1);

    // R5 exact timeout
    fb2High = 1;
    step(LIM + 2); check("R5 not yet latched", ouvFault, 1'b0);
    check("R5 run1 before timeout", run1, 1'b1);
    step(1); check("R5 latched", ouvFault, 1'b1);
    check("R5 run1 low", run1, 1'b0);
    check("R5 run2 low", run2, 1'b0);

    // R7 release rules
    fb2High = 0; vssCollapsed = 0;
    step(6); check("R7 holds without toggle", ouvFault, 1'b1);
    enableIn = 1; step(4); enableIn = 0; step(4);
    check("R7 toggle with supply up ignored", ouvFault, 1'b1);
    vssCollapsed = 1; fb1High = 1;
    step(3);
    enableIn = 1; step(4); enableIn = 0; step(4);
    check("R7 holds while feedback high", ouvFault, 1'b1);
    check("R7 run1 low while latched", run1, 1'b0);
    fb1High = 0;
    step(6);
    check("R7 released", ouvFault, 1'b0);
    check("R7 restarted", run1, 1'b1);

    // R7 release by undervoltage toggle
    fb1High = 1;
    step(LIM + 4); check("R5 second latch", ouvFault, 1'b1);
    fb1High = 0;
    step(4); check("R7 held before uv toggle", ouvFault, 1'b1);
    uvOk = 0; step(4); uvOk = 1;
    step(6);
    check("R7 released by uv toggle", ouvFault, 1'b0);
    check("R7 restarted after uv toggle", run1, 1'b1);

    // R1/R2 random flag combinations
    for (int it = 0; it < 40; it++) begin
      logic vr, uv, ov, en, pr;
      vr = 1'($urandom_range(0, 3) != 0);
      uv = 1'($urandom_range(0, 3) != 0);
      ov = 1'($urandom_range(0, 3) == 0);
      en = 1'($urandom_range(0, 1));
      pr = 1'($urandom_range(0, 1));
      vrefOk = vr; uvOk = uv; ovFault = ov; enableIn = en; programIn = pr;
      step(6);
      check("R2 random run1", run1, expRun1(vr, uv, ov, en, pr));
      check("R1 random run2", run2, 1'b0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule